// File: doc/BRIEF.md
# Serial Chained Eight-Channel Output Latch

This block is the digital front end of an eight-way switch bank. A host writes channel states over a four-wire serial link made of a select, a clock, a data input and a data output. Serial bits pass through an internal shift register. The register is copied into the channel latches only when the select is released after a whole number of bytes. Any other frame is thrown away and the latches keep their value. Because the data output carries the bit that leaves the far end of the shift register, several devices can share one select and one clock and be fed in series, each one passing longer frames on to the next.

The serial pins are asynchronous to the system clock. They are synchronised into the system clock domain and reduced to edge pulses, so the system clock must run at least four times faster than the serial clock. An active-low disable input clears the shift register and the channel latches at once, without waiting for a clock edge. A run of rejected frames forces every channel off until a valid frame arrives. On each release of the select, one of two single-cycle pulses reports whether the frame was taken or refused.

Top module: `spi_chain_outlatch`

## Requirements
- R1: While the select is low, each rising serial clock edge shifts the data input into the least significant end of the shift register. Frames are therefore sent most significant bit first.
- R2: `so_oe` is 1 only while the select is low and 0 while it is high. The data output is tristated whenever `so_oe` is 0.
- R3: When the select falls, `so_data` presents bit NUM_CH-1 of the shift register. After each falling serial clock edge it presents the new bit NUM_CH-1, so a frame of N bits leaves the first N-NUM_CH bits sent on `so_data`.
- R4: When the select rises after a non-zero whole multiple of NUM_CH rising clock edges, the shift register is copied to the channel latches and `frame_valid` pulses for exactly one system clock cycle.
- R5: When the select rises after any other number of clock edges, including zero, the latches are unchanged and `frame_rejected` pulses for one cycle.
- R6: `ch_out[i]` is 1 (channel on) when latch bit i is 1 and no forced-off condition holds. It is 0 (channel off) otherwise.
- R7: While `dis_n` is low, `ch_out` is 0 with no clock edge needed, and the shift register and latches are cleared. Channels stay off after `dis_n` returns high until a valid frame is latched.
- R8: After REJECT_LIMIT consecutive rejected frames (default 4), all channels are forced off until the next valid frame is accepted.
- R9: While the select is high, activity on the serial clock and data input leaves the shift register and outputs unchanged.
- R10: `frame_valid` and `frame_rejected` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 4x the serial clock |
| rst_n | input | 1 | Asynchronous active-low system reset |
| cs_n | input | 1 | Serial select, active low |
| sclk | input | 1 | Serial clock, idle high |
| si | input | 1 | Serial data input |
| dis_n | input | 1 | Asynchronous active-low disable of all channels |
| so_data | output | 1 | Serial data output value |
| so_oe | output | 1 | Output enable for the serial data output |
| ch_out | output | NUM_CH | Channel on/off states |
| frame_valid | output | 1 | One-cycle pulse: frame accepted |
| frame_rejected | output | 1 | One-cycle pulse: frame refused |

## Verification
The bench uses the defaults: eight channels, two synchroniser stages and a rejection limit of four. It drives the serial clock at one sixteenth of the system clock. With eight channels, frames of 16 and 24 bits exercise the pass-through of earlier bytes on the data output and the modulo-eight acceptance rule. Random lengths from 0 to 24 bits hit every remainder of the bit count. The limit of four lets a short burst of bad frames reach the forced-off state and leave it again on the next good frame.

// File: rtl/spi_chain_pkg.sv
package spi_chain_pkg;

   // Synchronised view of one asynchronous pin
   typedef struct packed {
      logic level;
      logic rise;
      logic fall;
   } edge_t;

   function automatic bit is_pow2(input int v);
      return (v > 0) && ((v & (v - 1)) == 0);
   endfunction

endpackage

// File: rtl/spi_chain_sync.sv
module spi_chain_sync
   import spi_chain_pkg::*;
#(
   parameter int STAGES    = 2,
   parameter bit RESET_VAL = 1'b1
) (
   input  logic  clk,
   input  logic  rst_n,
   input  logic  async_i,
   output edge_t edge_o
);

   if (STAGES < 1) begin : g_bad_stages
      $error("spi_chain_sync: STAGES must be at least 1");
   end

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= RESET_VAL;
         else        chain_q <= async_i;
      end
   end else begin : g_multi
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) chain_q <= {STAGES{RESET_VAL}};
         else        chain_q <= {chain_q[STAGES-2:0], async_i};
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= RESET_VAL;
      else        prev_q <= chain_q[STAGES-1];
   end

   always_comb begin
      edge_o.level = chain_q[STAGES-1];
      edge_o.rise  = chain_q[STAGES-1] & ~prev_q;
      edge_o.fall  = ~chain_q[STAGES-1] & prev_q;
   end

endmodule

// File: rtl/spi_chain_shifter.sv
module spi_chain_shifter
   import spi_chain_pkg::*;
#(
   parameter int NUM_CH = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dis_n,
   input  edge_t             cs_e,
   input  edge_t             sck_e,
   input  logic              si_lvl,
   output logic [NUM_CH-1:0] shreg_o,
   output logic              cnt_zero_o,
   output logic              seen_o,
   output logic              so_data_o,
   output logic              so_oe_o
);

   localparam int CNT_W = (NUM_CH > 2) ? $clog2(NUM_CH) : 1;

   logic [NUM_CH-1:0] sh_q;
   logic [CNT_W-1:0]  cnt_q;
   logic [CNT_W-1:0]  cnt_nx;
   logic              seen_q;
   logic              so_q;
   logic              oe_q;
   logic              selected;
   logic              shift_en;

   assign selected = ~cs_e.level;
   assign shift_en = sck_e.rise & selected;

   // Modulo counter: natural wrap for powers of two, explicit wrap otherwise
   if (is_pow2(NUM_CH)) begin : g_wrap_pow2
      assign cnt_nx = cnt_q + CNT_W'(1);
   end else begin : g_wrap_cmp
      assign cnt_nx = (cnt_q == CNT_W'(NUM_CH - 1)) ? '0 : cnt_q + CNT_W'(1);
   end

   always_ff @(posedge clk or negedge rst_n or negedge dis_n) begin
      if (!rst_n)        sh_q <= '0;
      else if (!dis_n)   sh_q <= '0;
      else if (shift_en) sh_q <= {sh_q[NUM_CH-2:0], si_lvl};
   end

   always_ff @(posedge clk or negedge rst_n or negedge dis_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (!dis_n) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (cs_e.fall) begin
         cnt_q  <= '0;
         seen_q <= 1'b0;
      end else if (shift_en) begin
         cnt_q  <= cnt_nx;
         seen_q <= 1'b1;
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         so_q <= 1'b0;
         oe_q <= 1'b0;
      end else begin
         oe_q <= selected;
         if (cs_e.fall || (sck_e.fall && selected))
            so_q <= sh_q[NUM_CH-1];
      end
   end

   assign shreg_o    = sh_q;
   assign cnt_zero_o = (cnt_q == '0);
   assign seen_o     = seen_q;
   assign so_data_o  = so_q;
   assign so_oe_o    = oe_q;

endmodule

// File: rtl/spi_chain_gate.sv
module spi_chain_gate #(
   parameter int NUM_CH       = 8,
   parameter int REJECT_LIMIT = 4,
   parameter int REJ_W        = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              dis_n,
   input  logic              cs_rise,
   input  logic [NUM_CH-1:0] shreg_i,
   input  logic              cnt_zero_i,
   input  logic              seen_i,
   output logic [NUM_CH-1:0] ch_out_o,
   output logic              frame_valid_o,
   output logic              frame_rejected_o,
   output logic [NUM_CH-1:0] latch_o,
   output logic [REJ_W-1:0]  rej_o
);

   logic [NUM_CH-1:0] latch_q;
   logic              accept;
   logic              refuse;
   logic              valid_q;
   logic              rej_pulse_q;
   logic              force_off;

   assign accept = cs_rise & seen_i & cnt_zero_i;
   assign refuse = cs_rise & ~accept;

   always_ff @(posedge clk or negedge rst_n or negedge dis_n) begin
      if (!rst_n)      latch_q <= '0;
      else if (!dis_n) latch_q <= '0;
      else if (accept) latch_q <= shreg_i;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q     <= 1'b0;
         rej_pulse_q <= 1'b0;
      end else begin
         valid_q     <= accept;
         rej_pulse_q <= refuse;
      end
   end

   if (REJECT_LIMIT > 0) begin : g_watchdog
      logic [REJ_W-1:0] rej_q;
      logic             force_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            rej_q   <= '0;
            force_q <= 1'b0;
         end else if (accept) begin
            rej_q   <= '0;
            force_q <= 1'b0;
         end else if (refuse) begin
            if (int'(rej_q) < REJECT_LIMIT) rej_q <= rej_q + REJ_W'(1);
            if (int'(rej_q) + 1 >= REJECT_LIMIT) force_q <= 1'b1;
         end
      end
      assign force_off = force_q;
      assign rej_o     = rej_q;
   end else begin : g_no_watchdog
      assign force_off = 1'b0;
      assign rej_o     = '0;
   end

   assign ch_out_o         = force_off ? '0 : latch_q;
   assign frame_valid_o    = valid_q;
   assign frame_rejected_o = rej_pulse_q;
   assign latch_o          = latch_q;

endmodule

// File: rtl/spi_chain_outlatch.sv
module spi_chain_outlatch
   import spi_chain_pkg::*;
#(
   parameter int NUM_CH       = 8,
   parameter int SYNC_STAGES  = 2,
   parameter int REJECT_LIMIT = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cs_n,
   input  logic              sclk,
   input  logic              si,
   input  logic              dis_n,
   output logic              so_data,
   output logic              so_oe,
   output logic [NUM_CH-1:0] ch_out,
   output logic              frame_valid,
   output logic              frame_rejected
);

   localparam int REJ_W = $clog2(REJECT_LIMIT + 2);

   if (NUM_CH < 2) begin : g_bad_width
      $error("spi_chain_outlatch: NUM_CH must be at least 2");
   end
   if (REJECT_LIMIT < 0) begin : g_bad_limit
      $error("spi_chain_outlatch: REJECT_LIMIT must not be negative");
   end

   edge_t             cs_e;
   edge_t             sck_e;
   edge_t             si_e;
   logic [NUM_CH-1:0] shreg_w;
   logic [NUM_CH-1:0] latch_w;
   logic [REJ_W-1:0]  rej_w;
   logic              cnt_zero_w;
   logic              seen_w;

   spi_chain_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_cs_sync (
      .clk(clk), .rst_n(rst_n), .async_i(cs_n), .edge_o(cs_e));

   spi_chain_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b1)) u_sck_sync (
      .clk(clk), .rst_n(rst_n), .async_i(sclk), .edge_o(sck_e));

   spi_chain_sync #(.STAGES(SYNC_STAGES), .RESET_VAL(1'b0)) u_si_sync (
      .clk(clk), .rst_n(rst_n), .async_i(si), .edge_o(si_e));

   spi_chain_shifter #(.NUM_CH(NUM_CH)) u_shifter (
      .clk        (clk),
      .rst_n      (rst_n),
      .dis_n      (dis_n),
      .cs_e       (cs_e),
      .sck_e      (sck_e),
      .si_lvl     (si_e.level),
      .shreg_o    (shreg_w),
      .cnt_zero_o (cnt_zero_w),
      .seen_o     (seen_w),
      .so_data_o  (so_data),
      .so_oe_o    (so_oe)
   );

   spi_chain_gate #(.NUM_CH(NUM_CH), .REJECT_LIMIT(REJECT_LIMIT), .REJ_W(REJ_W)) u_gate (
      .clk              (clk),
      .rst_n            (rst_n),
      .dis_n            (dis_n),
      .cs_rise          (cs_e.rise),
      .shreg_i          (shreg_w),
      .cnt_zero_i       (cnt_zero_w),
      .seen_i           (seen_w),
      .ch_out_o         (ch_out),
      .frame_valid_o    (frame_valid),
      .frame_rejected_o (frame_rejected),
      .latch_o          (latch_w),
      .rej_o            (rej_w)
   );

endmodule

// File: rtl/spi_chain_outlatch_chk.sv
module spi_chain_outlatch_chk #(
   parameter int NUM_CH       = 8,
   parameter int REJECT_LIMIT = 4,
   parameter int REJ_W        = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              dis_n,
   input logic              so_data,
   input logic              so_oe,
   input logic [NUM_CH-1:0] ch_out,
   input logic              frame_valid,
   input logic              frame_rejected,
   input logic [NUM_CH-1:0] shreg_w,
   input logic [NUM_CH-1:0] latch_w,
   input logic [REJ_W-1:0]  rej_w
);

   AST_PULSES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
      !(frame_valid && frame_rejected)); // R10

   AST_VALID_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      frame_valid |=> !frame_valid); // R4

   AST_VALID_COPIES: assert property (@(posedge clk) disable iff (!rst_n || !dis_n)
      frame_valid |-> latch_w == $past(shreg_w)); // R4

   AST_REJECT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n || !dis_n)
      frame_rejected |-> $stable(latch_w)); // R5

   AST_DISABLE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
      !dis_n |-> ch_out == '0); // R7

   AST_SO_START_MSB: assert property (@(posedge clk) disable iff (!rst_n || !dis_n)
      $rose(so_oe) |-> so_data == $past(shreg_w[NUM_CH-1])); // R3

   if (REJECT_LIMIT > 0) begin : g_force_chk
      AST_FORCED_OFF: assert property (@(posedge clk) disable iff (!rst_n)
         (int'(rej_w) >= REJECT_LIMIT) |-> ch_out == '0); // R8
   end

endmodule

bind spi_chain_outlatch spi_chain_outlatch_chk #(
   .NUM_CH(NUM_CH), .REJECT_LIMIT(REJECT_LIMIT), .REJ_W(REJ_W)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .dis_n          (dis_n),
   .so_data        (so_data),
   .so_oe          (so_oe),
   .ch_out         (ch_out),
   .frame_valid    (frame_valid),
   .frame_rejected (frame_rejected),
   .shreg_w        (shreg_w),
   .latch_w        (latch_w),
   .rej_w          (rej_w)
);

// File: tb/spi_chain_outlatch_tb_top.sv
`timescale 1ns/1ps
module spi_chain_outlatch_tb_top;

   localparam int NCH   = 8;
   localparam int LIMIT = 4;
   localparam int HALF  = 8;

   logic           clk = 1'b0;
   logic           rst_n = 1'b0;
   logic           cs_n = 1'b1;
   logic           sclk = 1'b1;
   logic           si = 1'b0;
   logic           dis_n = 1'b1;
   logic           so_data;
   logic           so_oe;
   logic [NCH-1:0] ch_out;
   logic           frame_valid;
   logic           frame_rejected;

   int checks = 0;
   int errors = 0;
   int vcnt = 0;
   int rcnt = 0;
   bit done = 0;

   logic [NCH-1:0] m_sh = '0;
   logic [NCH-1:0] m_latch = '0;
   int             m_rej = 0;
   bit             m_force = 0;

   always #5 clk = ~clk;

   spi_chain_outlatch #(.NUM_CH(NCH), .SYNC_STAGES(2), .REJECT_LIMIT(LIMIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sclk(sclk), .si(si), .dis_n(dis_n),
      .so_data(so_data), .so_oe(so_oe), .ch_out(ch_out),
      .frame_valid(frame_valid), .frame_rejected(frame_rejected));

   always @(posedge clk) begin
      if (frame_valid)    vcnt <= vcnt + 1;
      if (frame_rejected) rcnt <= rcnt + 1;
   end

   function automatic logic [NCH-1:0] exp_out();
      return m_force ? '0 : m_latch;
   endfunction

   function automatic bit frame_ok(input int n);
      return (n > 0) && (n % NCH == 0);
   endfunction

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wclk(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic send_frame(input logic [31:0] data, input int n);
      int v0, r0;
      bit ok;
      v0 = vcnt;
      r0 = rcnt;
      cs_n = 1'b0;
      wclk(HALF);
      chk("R2 so_oe on while selected", so_oe, 1);
      chk("R3 R9 SO shows MSB at select", so_data, m_sh[NCH-1]);
      for (int i = n - 1; i >= 0; i--) begin
         sclk = 1'b0;
         si   = data[i];
         wclk(HALF);
         chk("R3 SO pass-through bit", so_data, m_sh[NCH-1]);
         sclk = 1'b1;
         wclk(HALF);
         m_sh = {m_sh[NCH-2:0], data[i]}; // R1 model shift
      end
      cs_n = 1'b1;
      wclk(HALF);
      ok = frame_ok(n);
      if (ok) begin
         m_latch = m_sh;
         m_rej   = 0;
         m_force = 0;
      end else begin
         if (m_rej < LIMIT) m_rej++;
         if (m_rej >= LIMIT) m_force = 1;
      end
      chk("R2 so_oe off when deselected", so_oe, 0);
      chk("R4 valid pulse count", vcnt - v0, ok ? 1 : 0);
      chk("R5 reject pulse count", rcnt - r0, ok ? 0 : 1);
      chk(ok ? "R1 R4 R6 latched outputs" : "R5 R8 outputs after reject", ch_out, exp_out());
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5A17));
      wclk(4);
      rst_n = 1'b1;
      wclk(6);
      chk("R6 reset outputs off", ch_out, 0);
      chk("R2 reset so_oe off", so_oe, 0);
      chk("R10 no pulse at reset", {frame_valid, frame_rejected}, 0);

      // basic byte
      send_frame(32'hA5, 8);
      // chained frame: the last byte stays, the first byte leaves on SO
      send_frame(32'h3C_C3, 16);
      send_frame(32'h81_42_E7, 24);
      // short and empty frames are refused
      send_frame(32'h7F, 7);
      send_frame(32'h0, 0);
      send_frame(32'h1FF, 9);
      // fourth rejection in a row forces the outputs off (R8)
      send_frame(32'h3, 3);
      chk("R8 forced off after limit", ch_out, 0);
      send_frame(32'h5, 5);
      send_frame(32'h96, 8);
      chk("R8 valid frame lifts force", ch_out, 8'h96);

      // clock and data activity while deselected is ignored
      for (int k = 0; k < 12; k++) begin
         sclk = ~sclk;
         si   = $urandom_range(0, 1);
         wclk(HALF);
      end
      sclk = 1'b1;
      wclk(HALF);
      chk("R9 outputs unchanged when deselected", ch_out, exp_out());
      chk("R9 SO tristated when deselected", so_oe, 0);
      send_frame(32'h0, 0);

      // asynchronous disable
      send_frame(32'hFF, 8);
      @(negedge clk);
      dis_n = 1'b0;
      #1;
      chk("R7 outputs off at once", ch_out, 0);
      wclk(3);
      dis_n = 1'b1;
      m_latch = '0;
      m_sh    = '0;
      wclk(6);
      chk("R7 outputs stay off after release", ch_out, 0);
      send_frame(32'hF0F, 12);
      chk("R7 still off after refused frame", ch_out, 0);
      send_frame(32'h5A, 8);

      // random frames
      for (int f = 0; f < 40; f++) begin
         int n;
         if ($urandom_range(0, 2) == 0) n = NCH * $urandom_range(1, 3);
         else                           n = $urandom_range(0, 24);
         send_frame($urandom, n);
      end

      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

endmodule